// File: doc/BRIEF.md
# Two-Wire Bus Monitor

This block watches the clock and data lines of a two-wire serial bus without ever driving them. It turns the traffic into a stream of events. Each event carries a valid strobe and a kind code. The codes cover a bus start, a repeated start, a stop and a completed packet. A completed packet reports its eight data bits, its acknowledge bit, whether it was the address packet, and the direction flag.

Alongside the events, three single-cycle error pulses report framing that the bus rules forbid:
- a start followed by a stop with no address packet between them;
- a packet cut short by a start or a stop;
- a stop seen while no transaction is open.

Both lines pass through two-flop synchronizers, so the system clock must run much faster than the bus clock. All decoding works from edges, so a slave may hold the bus clock low for any length of time.

Top module: `twi_bus_monitor`

## Requirements
- R1: While `rst_n` is low, and after it is released with both lines high, every output is 0 and no transaction is open.
- R2: Data falling while the bus clock is high, with no transaction open, gives one event of kind 0 (START) and opens a transaction. Every result appears 3 system clocks after the line change that causes it.
- R3: Each data bit is sampled on a rising bus clock edge and counted when that high period ends with a falling edge. After the ninth counted bit, one event of kind 3 (PACKET) is produced. `ev_byte` holds the first eight bits, first bit in bit 7. `ev_ack` is 1 when the ninth bit was low and 0 when it was high.
- R4: The first packet after a START or repeated START has `ev_addr`=1, and `ev_rw` equals bit 0 of its byte. Later packets have `ev_addr`=0 and `ev_rw`=0.
- R5: Data falling while the clock is high inside an open transaction gives an event of kind 1 (RESTART). It clears the bit count, so the next packet is again an address packet.
- R6: Data rising while the clock is high inside an open transaction gives an event of kind 2 (STOP) and closes the transaction.
- R7: A STOP with no completed packet and no partial bits since the latest START or RESTART also raises `err_empty` in the same cycle.
- R8: A START/RESTART or STOP that arrives after 1 to 8 counted bits of a packet raises `err_trunc` in the same cycle as that event.
- R9: Data rising while the clock is high with no transaction open raises `err_stray`, with no event.
- R10: Bus clock pulses with no transaction open produce no event and no error.
- R11: A bus clock low period of any length, for example hundreds of system clocks, leaves the decoded result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| ev_valid | output | 1 | One-cycle event strobe |
| ev_kind | output | 2 | 0 START, 1 RESTART, 2 STOP, 3 PACKET |
| ev_byte | output | 8 | Packet byte, first bit in bit 7 |
| ev_ack | output | 1 | 1 when the ninth bit was low |
| ev_addr | output | 1 | Packet is the address packet |
| ev_rw | output | 1 | Direction bit of the address packet |
| err_empty | output | 1 | Start followed by stop with nothing between |
| err_trunc | output | 1 | Packet cut short by start or stop |
| err_stray | output | 1 | Stop seen with no transaction open |

## Verification
Every event and error pulse appears 3 system clocks after the line change that causes it:
- a START, RESTART or STOP follows the data edge;
- a PACKET follows the falling clock edge of the ninth bit.

The bench changes the lines only at falling system-clock edges and holds every bus level for several system clocks. Because of that, exact cycle counting is not needed. A monitor samples the outputs at each falling system edge and pops the next expected item whenever any strobe is high, so the results must arrive in order and one at a time. Any strobe with no queued expectation counts as a failure, and so does an expectation left in the queue at the end.

// File: rtl/twi_bus_monitor.sv
module twi_bus_monitor (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       ev_valid,
  output logic [1:0] ev_kind,
  output logic [7:0] ev_byte,
  output logic       ev_ack,
  output logic       ev_addr,
  output logic       ev_rw,
  output logic       err_empty,
  output logic       err_trunc,
  output logic       err_stray
);
  localparam logic [1:0] K_START = 2'd0, K_RESTART = 2'd1, K_STOP = 2'd2, K_PKT = 2'd3;
  localparam int unsigned PKT_BITS = 9;

  logic [2:0] scl_p, sda_p;
  logic       busy, first, have, bit_l;
  logic [3:0] bitcnt;
  logic [7:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  wire scl_hi  = scl_p[1] & scl_p[2];
  wire start_c = scl_hi & sda_p[2] & ~sda_p[1];
  wire stop_c  = scl_hi & ~sda_p[2] & sda_p[1];
  wire rise_c  = scl_p[1] & ~scl_p[2];
  wire fall_c  = ~scl_p[1] & scl_p[2];
  wire partial = bitcnt != 4'd0;

  always_ff @(posedge clk) begin
    ev_valid  <= 1'b0;
    ev_kind   <= '0;
    ev_byte   <= '0;
    ev_ack    <= 1'b0;
    ev_addr   <= 1'b0;
    ev_rw     <= 1'b0;
    err_empty <= 1'b0;
    err_trunc <= 1'b0;
    err_stray <= 1'b0;
    if (!rst_n) begin
      busy   <= 1'b0;
      first  <= 1'b0;
      have   <= 1'b0;
      bit_l  <= 1'b0;
      bitcnt <= '0;
      shreg  <= '0;
    end else if (start_c) begin
      ev_valid  <= 1'b1;
      ev_kind   <= busy ? K_RESTART : K_START;
      err_trunc <= busy & partial;
      busy      <= 1'b1;
      first     <= 1'b1;
      have      <= 1'b0;
      bitcnt    <= '0;
    end else if (stop_c) begin
      have <= 1'b0;
      if (busy) begin
        ev_valid  <= 1'b1;
        ev_kind   <= K_STOP;
        err_trunc <= partial;
        err_empty <= first & ~partial;
        busy      <= 1'b0;
        first     <= 1'b0;
        bitcnt    <= '0;
      end else begin
        err_stray <= 1'b1;
      end
    end else if (rise_c) begin
      bit_l <= sda_p[1];
      have  <= busy;
    end else if (fall_c && have) begin
      have <= 1'b0;
      if (bitcnt == 4'(PKT_BITS - 1)) begin
        ev_valid <= 1'b1;
        ev_kind  <= K_PKT;
        ev_byte  <= shreg;
        ev_ack   <= ~bit_l;
        ev_addr  <= first;
        ev_rw    <= first & shreg[0];
        first    <= 1'b0;
        bitcnt   <= '0;
      end else begin
        shreg  <= {shreg[6:0], bit_l};
        bitcnt <= bitcnt + 4'd1;
      end
    end
  end

  assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt < 4'(PKT_BITS));
  assert_pkt_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == K_PKT) |-> bitcnt == 4'd0);
  assert_addr_is_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr |-> (ev_valid && ev_kind == K_PKT));
  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bitcnt == 4'd0);
  assert_empty_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_empty |-> (ev_valid && ev_kind == K_STOP));
  assert_trunc_on_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_trunc |-> (ev_valid && ev_kind != K_PKT && ev_kind != K_START));
  assert_stray_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_stray |-> !ev_valid);
endmodule

// File: tb/tb_twi_bus_monitor.sv
module tb_twi_bus_monitor;
  logic clk = 0, rst_n = 0, scl = 1, sda = 1;
  logic ev_valid, ev_ack, ev_addr, ev_rw, err_empty, err_trunc, err_stray;
  logic [1:0] ev_kind;
  logic [7:0] ev_byte;
  int checks = 0, errors = 0;
  bit done = 0;
  localparam int H = 6;

  always #2 clk = ~clk;

  twi_bus_monitor dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte), .ev_ack(ev_ack),
    .ev_addr(ev_addr), .ev_rw(ev_rw), .err_empty(err_empty), .err_trunc(err_trunc),
    .err_stray(err_stray));

  logic [16:0] exp_q[$];
  string tag_q[$];

  wire [16:0] obs = {ev_valid, ev_kind, ev_byte, ev_ack, ev_addr, ev_rw, err_empty, err_trunc, err_stray};

  function automatic logic [16:0] mk(bit v, logic [1:0] k, logic [7:0] b, bit a, bit ad, bit rw,
                                     bit e, bit t, bit s);
    return {v, k, b, a, ad, rw, e, t, s};
  endfunction

  task automatic expect_item(logic [16:0] x, string tag);
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && (obs[16] || obs[2:0] != 3'b000)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected output: actual=%h expected=none", obs);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (obs !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, obs, e);
        end
      end
    end
  end

  task automatic bus_start(string tag);
    expect_item(mk(1, 2'd0, 8'h00, 0, 0, 0, 0, 0, 0), tag);
    wait_cyc(H); sda = 0; wait_cyc(H); scl = 0; wait_cyc(H);
  endtask

  task automatic bus_restart(bit trunc, string tag);
    expect_item(mk(1, 2'd1, 8'h00, 0, 0, 0, 0, trunc, 0), tag);
    sda = 1; wait_cyc(H); scl = 1; wait_cyc(H); sda = 0; wait_cyc(H); scl = 0; wait_cyc(H);
  endtask

  task automatic bus_stop(bit empty, bit trunc, string tag);
    expect_item(mk(1, 2'd2, 8'h00, 0, 0, 0, empty, trunc, 0), tag);
    sda = 0; wait_cyc(H); scl = 1; wait_cyc(H); sda = 1; wait_cyc(H);
  endtask

  task automatic send_bit(bit v, int lo);
    sda = v; wait_cyc(lo); scl = 1; wait_cyc(H); scl = 0; wait_cyc(H);
  endtask

  task automatic send_byte(logic [7:0] b, bit ack, bit is_addr, int lo, string tag);
    expect_item(mk(1, 2'd3, b, ack, is_addr, is_addr & b[0], 0, 0, 0), tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i], lo);
    send_bit(~ack, lo);
  endtask

  initial begin
    wait_cyc(4);
    checks++;
    if (obs !== 17'h0) begin
      errors++;
      $display("FAIL R1 reset: actual=%h expected=%h", obs, 17'h0);
    end
    rst_n = 1;
    wait_cyc(8);
    checks++;
    if (obs !== 17'h0) begin
      errors++;
      $display("FAIL R1 idle after reset: actual=%h expected=%h", obs, 17'h0);
    end

    bus_start("R2 start");
    send_byte(8'hA1, 1, 1, H, "R3 R4 address read ack");
    send_byte(8'h5C, 0, 0, H, "R3 data nack");
    bus_stop(0, 0, "R6 stop");

    bus_start("R2 start before empty");
    bus_stop(1, 0, "R7 empty message");

    bus_start("R2 start");
    send_byte(8'h40, 1, 1, H, "R4 address write");
    send_byte(8'h3C, 1, 0, H, "R4 data after address");
    bus_restart(0, "R5 repeated start");
    send_byte(8'h41, 0, 1, H, "R5 address after restart");
    bus_stop(0, 0, "R6 stop after restart");

    bus_start("R2 start");
    send_byte(8'h30, 1, 1, H, "R4 address");
    for (int i = 0; i < 3; i++) send_bit(1'b1, H);
    bus_stop(0, 1, "R8 stop mid packet");

    bus_start("R2 start");
    for (int i = 0; i < 5; i++) send_bit(i[0], H);
    bus_restart(1, "R8 restart mid packet");
    send_byte(8'h07, 1, 1, H, "R8 address after cut restart");
    for (int i = 0; i < 8; i++) send_bit(1'b0, H);
    bus_stop(0, 1, "R8 stop after 8 bits");

    expect_item(mk(0, 2'd0, 8'h00, 0, 0, 0, 0, 0, 1), "R9 stray stop");
    scl = 0; wait_cyc(H); sda = 0; wait_cyc(H); scl = 1; wait_cyc(H); sda = 1; wait_cyc(H);

    for (int i = 0; i < 6; i++) begin
      scl = 0; wait_cyc(H); sda = i[0]; wait_cyc(H); sda = 1; wait_cyc(H); scl = 1; wait_cyc(H);
    end

    bus_start("R11 start");
    send_byte(8'h96, 1, 1, 400, "R11 stretched address");
    send_byte(8'h69, 0, 0, 250, "R11 stretched data");
    bus_stop(0, 0, "R11 stop");

    wait_cyc(20);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing outputs: actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule